// File: doc/BRIEF.md
# Isolated Instrument Bus Interface Controller

This block is the bus-side controller of an instrument that sits on a seven-line parallel instrument bus. The bus control lines are active low. A mode line (`mre_ni`) marks address bytes when it is low. The talker strobes each byte with `dav_ni`. A listener signals acceptance by driving DAC high, and a receiver signals that it is busy by pulling RFD low. The controller decodes address bytes against a configured address. It enters listen or talk mode and latches the remote-enable request into an internal remote line.

In listen mode, program bytes (mode line high) are checked against the range of codes the instrument accepts. An acceptable byte is handed to a separately clocked interpreter over a four-phase request/acknowledge pair. The bus is held with DAC high and RFD low until the interpreter acknowledges. A dedicated end code finishes programming. After it, program bytes are ignored until the instrument is addressed to listen again.

In talk mode, the interpreter offers output characters through a second request/acknowledge pair. The block puts each character on the bus, asserts DAV and waits for the listener's DAC before it releases the strobe. Every asynchronous input passes through a multi-flop synchronizer.

Top module: `bus_ctl`

## Requirements
- R1: After reset `dac_o` is 0, `rfd_o` is 1, `dav_no` is 1, `rmt_no` is 1, `data_oe_o`, `char_req_o`, `tx_ack_o`, `listen_o` and `talk_o` are 0.
- R2: An address byte (`mre_ni` low while `dav_ni` is low) whose bits [4:0] equal `addr_i` and whose bit 6 is 1 sets listen mode and clears talk mode; bit 5 is not decoded.
- R3: An address byte whose bits [4:0] equal `addr_i` and whose bit 6 is 0 sets talk mode and clears listen mode; an address byte with other bits [4:0] leaves both modes unchanged, and the two modes are never set together.
- R4: On each own listen address, `rmt_no` takes the level `ren_ni` had when the byte was decoded (low means remote), and holds it until the next own listen address.
- R5: Every address byte is acknowledged: `dac_o` goes high only after the strobe is seen and the address and `ren_ni` were checked, and returns low once `dav_ni` is high again.
- R6: In listen mode, a program byte (mode line high) with code 0x30 to 0x5A inclusive is accepted: `dac_o` rises while `rfd_o` drops in the same cycle, and `char_req_o` rises with the code on `char_o`, held stable while the request is high.
- R7: `rfd_o` stays low while `char_req_o` is high and rises only after `char_ack_i` was seen high; `char_req_o` drops at the same time, and the next byte waits for `char_ack_i` to fall.
- R8: In listen mode, a program byte outside 0x30 to 0x5A is acknowledged with `dac_o` high while `rfd_o` stays high, and it is not forwarded.
- R9: The end code 0x45 is forwarded like any accepted byte, after which listen mode is cleared; later program bytes raise neither `dac_o` nor `char_req_o`.
- R10: In talk mode, a rising `tx_req_i` puts `tx_data_i` on `data_o` with `data_oe_o` high and then drives `dav_no` low. `dav_no` is released and `tx_ack_o` raised only after `dac_i` is seen high. `tx_ack_o` drops after `tx_req_i` drops.
- R11: Outside talk mode `tx_req_i` is ignored: `dav_no` stays high and `data_oe_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Configured bus address |
| mre_ni | input | 1 | Mode line, low marks address bytes |
| dav_ni | input | 1 | Data-valid strobe from the talker, active low |
| ren_ni | input | 1 | Remote enable, active low |
| dac_i | input | 1 | Data-accepted from the listener, high when accepted |
| data_i | input | 7 | Bus data lines 1..7 as bits 0..6 |
| dav_no | output | 1 | Data-valid strobe driven in talk mode, active low |
| dac_o | output | 1 | Data accepted, high when accepted |
| rfd_o | output | 1 | Ready for data, low while busy |
| data_o | output | 7 | Output character for the bus |
| data_oe_o | output | 1 | Enable for `data_o` onto the bus |
| rmt_no | output | 1 | Internal remote line, low means remote control |
| listen_o | output | 1 | Addressed to listen |
| talk_o | output | 1 | Addressed to talk |
| char_o | output | 7 | Program character to the interpreter |
| char_req_o | output | 1 | Request to the interpreter, four-phase |
| char_ack_i | input | 1 | Interpreter acknowledge, asynchronous |
| tx_data_i | input | 7 | Output character from the interpreter |
| tx_req_i | input | 1 | Output request from the interpreter, asynchronous |
| tx_ack_o | output | 1 | Output acknowledge to the interpreter |

## Verification
A wrong receive state shows at the ports within a handshake. It can leave DAC stuck high, which stalls the talker. It can leave RFD low with no request pending, which stalls the bus. It can also fail to clear listen mode after the end code, so a later byte is acknowledged that should have been ignored. A wrong address decode shows up at the next byte as wrong values on `listen_o`, `talk_o` or `rmt_no`. A talk-side fault shows up at the first character as DAV asserted without driven data, or as a strobe released before DAC. Every such point is reached three clock cycles after the input that causes it, one cycle more than the synchronizer depth.

// File: rtl/bus_ctl_pkg.sv
package bus_ctl_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_HANDOFF,
    RX_ACK_LOW,
    RX_WAIT_REL
  } rx_state_e;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_SETUP,
    TX_WAIT_DAC,
    TX_WAIT_REQ_LOW,
    TX_WAIT_DAC_LOW
  } tx_state_e;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bus_rx.sv
module bus_rx
  import bus_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 7,
  parameter logic [DATA_W-1:0] PROG_LO  = 7'h30,
  parameter logic [DATA_W-1:0] PROG_HI  = 7'h5A,
  parameter logic [DATA_W-1:0] END_CODE = 7'h45
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mre_n_i,
  input  logic              dav_n_i,
  input  logic              ren_n_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic              dac_o,
  output logic              rfd_o,
  output logic              rmt_no,
  output logic              listen_o,
  output logic              talk_o,
  output logic [DATA_W-1:0] char_o,
  output logic              req_o
);
  localparam int unsigned LSN_BIT = DATA_W - 1;

  rx_state_e state_q;
  logic      end_q;
  logic      own_addr;
  logic      prog_ok;

  assign own_addr = (data_i[ADDR_W-1:0] == addr_i);
  assign prog_ok  = (data_i >= PROG_LO) && (data_i <= PROG_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_IDLE;
      dac_o    <= 1'b0;
      rfd_o    <= 1'b1;
      rmt_no   <= 1'b1;
      listen_o <= 1'b0;
      talk_o   <= 1'b0;
      char_o   <= '0;
      req_o    <= 1'b0;
      end_q    <= 1'b0;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (!dav_n_i) begin
            if (!mre_n_i) begin
              // address byte: decode, latch remote, then acknowledge
              if (own_addr) begin
                if (data_i[LSN_BIT]) begin
                  listen_o <= 1'b1;
                  talk_o   <= 1'b0;
                  rmt_no   <= ren_n_i;
                end else begin
                  talk_o   <= 1'b1;
                  listen_o <= 1'b0;
                end
              end
              dac_o   <= 1'b1;
              state_q <= RX_WAIT_REL;
            end else if (listen_o) begin
              dac_o <= 1'b1;
              if (prog_ok) begin
                char_o  <= data_i;
                req_o   <= 1'b1;
                rfd_o   <= 1'b0;
                end_q   <= (data_i == END_CODE);
                state_q <= RX_HANDOFF;
              end else begin
                state_q <= RX_WAIT_REL;
              end
            end
          end
        end
        RX_HANDOFF: begin
          if (ack_i) begin
            req_o   <= 1'b0;
            rfd_o   <= 1'b1;
            state_q <= RX_ACK_LOW;
          end
        end
        RX_ACK_LOW: begin
          if (!ack_i) begin
            if (end_q) listen_o <= 1'b0;
            end_q   <= 1'b0;
            state_q <= RX_WAIT_REL;
          end
        end
        RX_WAIT_REL: begin
          if (dav_n_i) begin
            dac_o   <= 1'b0;
            state_q <= RX_IDLE;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_tx.sv
module bus_tx
  import bus_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              talk_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              dac_i,
  output logic              dav_no,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ack_o
);
  tx_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= TX_IDLE;
      dav_no    <= 1'b1;
      data_o    <= '0;
      data_oe_o <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (talk_i && req_i) begin
            data_o    <= tx_data_i;
            data_oe_o <= 1'b1;
            state_q   <= TX_SETUP;
          end
        end
        TX_SETUP: begin
          // one cycle of data setup before the strobe
          dav_no  <= 1'b0;
          state_q <= TX_WAIT_DAC;
        end
        TX_WAIT_DAC: begin
          if (dac_i) begin
            dav_no    <= 1'b1;
            data_oe_o <= 1'b0;
            ack_o     <= 1'b1;
            state_q   <= TX_WAIT_REQ_LOW;
          end
        end
        TX_WAIT_REQ_LOW: begin
          if (!req_i) begin
            ack_o   <= 1'b0;
            state_q <= TX_WAIT_DAC_LOW;
          end
        end
        TX_WAIT_DAC_LOW: begin
          if (!dac_i) state_q <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_ctl.sv
module bus_ctl #(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] PROG_LO  = 7'h30,
  parameter logic [DATA_W-1:0] PROG_HI  = 7'h5A,
  parameter logic [DATA_W-1:0] END_CODE = 7'h45
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mre_ni,
  input  logic              dav_ni,
  input  logic              ren_ni,
  input  logic              dac_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              dav_no,
  output logic              dac_o,
  output logic              rfd_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rmt_no,
  output logic              listen_o,
  output logic              talk_o,
  output logic [DATA_W-1:0] char_o,
  output logic              char_req_o,
  input  logic              char_ack_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_req_i,
  output logic              tx_ack_o
);
  localparam int unsigned CTL_W  = 6;
  localparam int unsigned SYNC_W = CTL_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {3'b111, 3'b000, {DATA_W{1'b0}}};

  logic [SYNC_W-1:0] raw, syn;
  logic              s_mre_n, s_dav_n, s_ren_n, s_dac, s_ack, s_tx_req;
  logic [DATA_W-1:0] s_data;

  assign raw = {mre_ni, dav_ni, ren_ni, dac_i, char_ack_i, tx_req_i, data_i};
  assign {s_mre_n, s_dav_n, s_ren_n, s_dac, s_ack, s_tx_req, s_data} = syn;

  bus_sync #(
    .W      (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  bus_rx #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PROG_LO (PROG_LO),
    .PROG_HI (PROG_HI),
    .END_CODE(END_CODE)
  ) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .mre_n_i (s_mre_n),
    .dav_n_i (s_dav_n),
    .ren_n_i (s_ren_n),
    .data_i  (s_data),
    .ack_i   (s_ack),
    .dac_o   (dac_o),
    .rfd_o   (rfd_o),
    .rmt_no  (rmt_no),
    .listen_o(listen_o),
    .talk_o  (talk_o),
    .char_o  (char_o),
    .req_o   (char_req_o)
  );

  bus_tx #(
    .DATA_W(DATA_W)
  ) i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .talk_i   (talk_o),
    .req_i    (s_tx_req),
    .tx_data_i(tx_data_i),
    .dac_i    (s_dac),
    .dav_no   (dav_no),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .ack_o    (tx_ack_o)
  );
endmodule

// File: rtl/bus_ctl_chk.sv
module bus_ctl_chk #(
  parameter int unsigned DATA_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dav_ni,
  input logic              dac_i,
  input logic              char_ack_i,
  input logic              dac_o,
  input logic              rfd_o,
  input logic              char_req_o,
  input logic [DATA_W-1:0] char_o,
  input logic              dav_no,
  input logic              data_oe_o,
  input logic              listen_o,
  input logic              talk_o
);
  localparam int unsigned LAT = SYNC_STAGES + 1;

  AST_ONE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(listen_o && talk_o)); // R3

  AST_DAC_AFTER_DAV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_o) |-> !$past(dav_ni, LAT)); // R5

  AST_CHAR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_req_o && $past(char_req_o)) |-> $stable(char_o)); // R6

  AST_BUSY_WHILE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_req_o |-> !rfd_o); // R7

  AST_RFD_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rfd_o) |-> $past(char_ack_i, LAT)); // R7

  AST_DAV_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dav_no |-> data_oe_o); // R10

  AST_DAV_HELD_FOR_DAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dav_no) |-> $past(dac_i, LAT)); // R10
endmodule

bind bus_ctl bus_ctl_chk #(
  .DATA_W     (DATA_W),
  .SYNC_STAGES(SYNC_STAGES)
) i_bus_ctl_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dav_ni    (dav_ni),
  .dac_i     (dac_i),
  .char_ack_i(char_ack_i),
  .dac_o     (dac_o),
  .rfd_o     (rfd_o),
  .char_req_o(char_req_o),
  .char_o    (char_o),
  .dav_no    (dav_no),
  .data_oe_o (data_oe_o),
  .listen_o  (listen_o),
  .talk_o    (talk_o)
);

// File: tb/test_bus_ctl.sv
`timescale 1ns/1ps
module test_bus_ctl;
  localparam logic [4:0] MY_ADDR = 5'h0B;
  localparam int END_C = 'h45;

  logic       clk = 0, int_clk = 0, rst_ni = 0;
  logic       mre_ni = 1, dav_ni = 1, ren_ni = 1, dac_i = 0;
  logic [6:0] data_i = '0, tx_data_i = '0;
  logic       tx_req_i = 0, char_ack_i = 0;
  logic       dav_no, dac_o, rfd_o, data_oe_o, rmt_no, listen_o, talk_o;
  logic       char_req_o, tx_ack_o;
  logic [6:0] data_o, char_o;

  int checks = 0, fails = 0;
  int got_cnt = 0;
  logic [6:0] got_char = '0;

  always #2 clk = ~clk;
  always #3.5 int_clk = ~int_clk;

  bus_ctl i_bus_ctl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(MY_ADDR),
    .mre_ni(mre_ni), .dav_ni(dav_ni), .ren_ni(ren_ni), .dac_i(dac_i),
    .data_i(data_i), .dav_no(dav_no), .dac_o(dac_o), .rfd_o(rfd_o),
    .data_o(data_o), .data_oe_o(data_oe_o), .rmt_no(rmt_no),
    .listen_o(listen_o), .talk_o(talk_o), .char_o(char_o),
    .char_req_o(char_req_o), .char_ack_i(char_ack_i),
    .tx_data_i(tx_data_i), .tx_req_i(tx_req_i), .tx_ack_o(tx_ack_o)
  );

  // interpreter model on its own clock
  always @(posedge int_clk) begin
    if (char_req_o && !char_ack_i) begin
      got_char   <= char_o;
      got_cnt    <= got_cnt + 1;
      char_ack_i <= 1'b1;
    end else if (!char_req_o && char_ack_i) begin
      char_ack_i <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_for(input int sel, input logic v, output bit ok);
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      case (sel)
        0: ok = (dac_o == v);
        1: ok = (rfd_o == v);
        2: ok = (dav_no == v);
        default: ok = (tx_ack_o == v);
      endcase
      if (ok) return;
    end
  endtask

  task automatic addr_byte(input logic [6:0] b, input logic ren, output bit ok);
    bit ok1, ok2;
    @(negedge clk);
    mre_ni = 0; ren_ni = ren; data_i = b;
    repeat (2) @(negedge clk);
    dav_ni = 0;
    wait_for(0, 1'b1, ok1);
    dav_ni = 1;
    wait_for(0, 1'b0, ok2);
    mre_ni = 1;
    ok = ok1 && ok2;
  endtask

  // returns rfd level seen in the first cycle of dac high
  task automatic prog_byte(input logic [6:0] b, output bit ok, output logic rfd_at);
    bit ok1, ok2, ok3;
    @(negedge clk);
    mre_ni = 1; data_i = b;
    repeat (2) @(negedge clk);
    dav_ni = 0;
    wait_for(0, 1'b1, ok1);
    rfd_at = rfd_o;
    dav_ni = 1;
    wait_for(0, 1'b0, ok2);
    wait_for(1, 1'b1, ok3);
    ok = ok1 && ok2 && ok3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    logic rfd_at;
    logic m_lsn, m_tlk, m_rmt_n;
    int cnt0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(dac_o == 0 && rfd_o == 1 && dav_no == 1 && rmt_no == 1, "R1 handshake lines",
          {dac_o, rfd_o, dav_no, rmt_no}, 4'b0111);
    check(!data_oe_o && !char_req_o && !tx_ack_o && !listen_o && !talk_o, "R1 modes",
          {data_oe_o, char_req_o, tx_ack_o, listen_o, talk_o}, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk);

    // address sweep against a bench model
    m_lsn = 0; m_tlk = 0; m_rmt_n = 1;
    for (int a = 0; a < 32; a++) begin
      for (int l = 0; l < 2; l++) begin
        for (int r = 0; r < 2; r++) begin
          logic [6:0] b;
          b = {l[0], a[0] ^ r[0], a[4:0]};
          addr_byte(b, r[0], ok);
          check(ok, "R5 address handshake", ok, 1);
          if (a[4:0] == MY_ADDR) begin
            if (l != 0) begin m_lsn = 1; m_tlk = 0; m_rmt_n = r[0]; end
            else        begin m_tlk = 1; m_lsn = 0; end
          end
          check(listen_o == m_lsn, "R2 listen mode", listen_o, m_lsn);
          check(talk_o == m_tlk, "R3 talk mode", talk_o, m_tlk);
          check(rmt_no == m_rmt_n, "R4 remote line", rmt_no, m_rmt_n);
        end
      end
    end

    // listen with remote, then sweep program codes
    addr_byte({1'b1, 1'b0, MY_ADDR}, 1'b0, ok);
    check(listen_o && !rmt_no, "R4 remote on listen", {listen_o, rmt_no}, 2'b10);
    for (int c = 0; c < 128; c++) begin
      bit acc;
      if (c == END_C) continue;
      acc = (c >= 'h30) && (c <= 'h5A);
      cnt0 = got_cnt;
      prog_byte(c[6:0], ok, rfd_at);
      if (acc) begin
        check(ok && rfd_at == 0, "R6 accept busy", rfd_at, 0);
        check(got_cnt == cnt0 + 1 && got_char == c[6:0], "R7 forwarded", got_char, c);
      end else begin
        check(ok && rfd_at == 1, "R8 reject ready", rfd_at, 1);
        check(got_cnt == cnt0, "R8 not forwarded", got_cnt - cnt0, 0);
      end
    end

    // end code
    cnt0 = got_cnt;
    prog_byte(7'(END_C), ok, rfd_at);
    check(ok && got_cnt == cnt0 + 1 && got_char == 7'(END_C), "R9 end forwarded", got_char, END_C);
    check(listen_o == 0, "R9 listen cleared", listen_o, 0);
    // byte after end must be ignored
    cnt0 = got_cnt;
    @(negedge clk);
    mre_ni = 1; data_i = 7'h31;
    repeat (2) @(negedge clk);
    dav_ni = 0;
    ok = 1;
    repeat (20) begin
      @(negedge clk);
      if (dac_o || char_req_o) ok = 0;
    end
    check(ok && got_cnt == cnt0, "R9 ignored after end", got_cnt - cnt0, 0);
    dav_ni = 1;
    repeat (4) @(negedge clk);

    // tx request ignored outside talk mode
    tx_data_i = 7'h55; tx_req_i = 1;
    ok = 1;
    repeat (20) begin
      @(negedge clk);
      if (!dav_no || data_oe_o) ok = 0;
    end
    check(ok, "R11 no talk, no strobe", dav_no, 1);
    tx_req_i = 0;
    repeat (4) @(negedge clk);

    // talk mode transfers
    addr_byte({1'b0, 1'b0, MY_ADDR}, 1'b1, ok);
    check(talk_o && !listen_o, "R3 talk addressed", talk_o, 1);
    for (int k = 0; k < 6; k++) begin
      logic [6:0] v;
      bit okt;
      v = 7'((k * 37 + 11) % 128);
      tx_data_i = v; tx_req_i = 1;
      wait_for(2, 1'b0, okt);
      check(okt && data_o == v && data_oe_o, "R10 data with strobe", data_o, v);
      repeat (6) @(negedge clk);
      check(dav_no == 0 && tx_ack_o == 0, "R10 strobe held for dac", dav_no, 0);
      dac_i = 1;
      wait_for(3, 1'b1, okt);
      check(okt && dav_no == 1, "R10 release after dac", dav_no, 1);
      tx_req_i = 0;
      wait_for(3, 1'b0, okt);
      check(okt, "R10 ack returns low", tx_ack_o, 0);
      dac_i = 0;
      repeat (6) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule